// File: doc/BRIEF.md
# Memory Self-Test Subtest Sequencer

This block walks through a small program of memory self-test steps and, for the step it is on, presents a fully decoded operation descriptor to a downstream command generator. Each step is a 16-bit word. Software packs four steps into each 64-bit program register and writes the registers through a simple write port; eight registers give a program of up to 32 steps.

A start pulse launches execution from step 0. The descriptor of the current step is held on the outputs, with `opValid` high, until the command generator pulses `opDone`; the block then moves to the next step. Execution ends after a step whose last-step flag is set, or after step 31 when no such flag is present. A stop pulse abandons a run, and a fail input from the data checker sets a sticky fail flag. When maintenance addressing is selected, the three data-complement bits of a step are reused as a port and DIMM selector.

Top module: `mbs_seq`

## Requirements
- R1: Program register r (write address r) holds steps 4r to 4r+3; step 4r+k sits in bits [63-16k : 48-16k], so step 4r occupies the top 16 bits. `opIndex` shows the number of the step being presented.
- R2: Bits of a step word are numbered 0 (MSB, word[15]) to 15 (LSB, word[0]). Bits 0-3 drive `opType` (0000 write, 0001 read); bits 4, 5, 6 drive `opCompl[2]`, `opCompl[1]`, `opCompl[0]` (complement on first, second, third subcommand); bit 7 drives `opRevAddr`; bit 8 drives `opRandAddr`; bits 9-11 drive `opDataMode` (000 fixed data); bits 14-15 drive `opRangeSel`.
- R3: A start pulse while idle makes `statBusy` and `opValid` high on the next cycle with `opIndex` = 0 and `statDone` cleared. A start pulse while busy is ignored: the index, busy and fail flags are unchanged.
- R4: While busy, the descriptor and `opIndex` stay stable until `opDone` is high on a clock edge; after that edge `opIndex` has advanced by one (unless the run ended).
- R5: Bit 12 of a step word is the last-step flag. When `opDone` completes a step carrying it, `statBusy` falls and `statDone` rises on the next cycle. `statBusy` and `statDone` are never both high.
- R6: When no step carries the last-step flag, the run completes (busy low, done high) after step 31 is acknowledged.
- R7: A stop pulse while busy clears `statBusy` on the next cycle and leaves `statDone` low, even when `opDone` completes the final step in the same cycle.
- R8: `failIn` sets `statFail`, which stays set until an accepted start clears it; when `failIn` and an accepted start coincide, `statFail` ends up set.
- R9: With `maintMode` high, `opCompl` reads 000, `opPort` is taken from bits 4-5 (bit 4 as MSB) and `opDimm` from bit 6; with `maintMode` low, `opPort` and `opDimm` read 0.
- R10: Bit 13 of a step word drives `opEcc`.
- R11: After reset `statBusy`, `statDone`, `statFail` and `opValid` are low and every program register reads as zero (all steps decode to an all-zero descriptor).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Program register write strobe |
| cfgWrAddr | input | 3 | Program register number |
| cfgWrData | input | 64 | Four packed step words |
| startPulse | input | 1 | Begin a run (ignored while busy) |
| stopPulse | input | 1 | Abandon the current run |
| maintMode | input | 1 | Reuse complement bits as port/DIMM selector |
| opDone | input | 1 | Command generator finished the presented step |
| failIn | input | 1 | Miscompare report from the data checker |
| opValid | output | 1 | A descriptor is being presented |
| opIndex | output | 5 | Number of the presented step |
| opType | output | 4 | Operation type |
| opCompl | output | 3 | Complement flags, first subcommand in the MSB |
| opRevAddr | output | 1 | Descending address order |
| opRandAddr | output | 1 | Random address order |
| opDataMode | output | 3 | Data pattern mode |
| opEcc | output | 1 | Generate and check data with ECC |
| opRangeSel | output | 2 | Address-range configuration select |
| opPort | output | 2 | Port selector in maintenance mode |
| opDimm | output | 1 | DIMM selector in maintenance mode |
| statBusy | output | 1 | Run in progress |
| statDone | output | 1 | Last run completed normally |
| statFail | output | 1 | Sticky failure flag |

## Verification
Two pairs of events can land on one clock edge: a stop pulse together with the `opDone` that acknowledges the final step, and a failure report together with an accepted start. The bench drives each pair on the same cycle on purpose, and judges the first by expecting busy low with done still low (stop has priority), the second by expecting the fail flag set while the new run is busy. A start pulse in the middle of a run is also provoked and judged by an unchanged step index and a fail flag that stays set.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  localparam int STEP_W = 16;

  // Step word, declared MSB first so a cast maps bit 0 of the
  // numbering onto the top field.
  typedef struct packed {
    logic [3:0] opType;
    logic [2:0] compl;
    logic       revAddr;
    logic       randAddr;
    logic [2:0] dataMode;
    logic       lastStep;
    logic       ecc;
    logic [1:0] rangeSel;
  } stepWord_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic clrIdx;
    logic incIdx;
  } seqStrobe_t;

endpackage

// File: rtl/mbs_datapath.sv
module mbs_datapath
  import mbs_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int SLOTS    = 4,
  parameter int REG_W    = 64,
  localparam int NUM_STEPS = NUM_REGS * SLOTS,
  localparam int IDX_W     = $clog2(NUM_STEPS),
  localparam int ADDR_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgWrAddr,
  input  logic [REG_W-1:0]  cfgWrData,
  input  logic              maintMode,
  input  seqStrobe_t        strobe,
  output logic [IDX_W-1:0]  opIndex,
  output logic [3:0]        opType,
  output logic [2:0]        opCompl,
  output logic              opRevAddr,
  output logic              opRandAddr,
  output logic [2:0]        opDataMode,
  output logic              opEcc,
  output logic [1:0]        opRangeSel,
  output logic [1:0]        opPort,
  output logic              opDimm,
  output logic              lastStep,
  output logic              idxAtEnd
);

  logic [REG_W-1:0]  progRegs [NUM_REGS];
  logic [STEP_W-1:0] steps    [NUM_STEPS];
  logic [IDX_W-1:0]  idxQ;
  stepWord_t         cur;

  // One storage register per program slot group.
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        progRegs[r] <= '0;
      end else if (cfgWrEn && (cfgWrAddr == ADDR_W'(r))) begin
        progRegs[r] <= cfgWrData;
      end
    end
  end

  // Unpack: the first step of a register lives in its top bits.
  for (genvar i = 0; i < NUM_STEPS; i++) begin : g_step
    assign steps[i] = progRegs[i / SLOTS][(SLOTS - 1 - (i % SLOTS)) * STEP_W +: STEP_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idxQ <= '0;
    end else if (strobe.clrIdx) begin
      idxQ <= '0;
    end else if (strobe.incIdx) begin
      idxQ <= idxQ + 1'b1;
    end
  end

  always_comb begin
    cur        = stepWord_t'(steps[idxQ]);
    opIndex    = idxQ;
    opType     = cur.opType;
    opRevAddr  = cur.revAddr;
    opRandAddr = cur.randAddr;
    opDataMode = cur.dataMode;
    opEcc      = cur.ecc;
    opRangeSel = cur.rangeSel;
    lastStep   = cur.lastStep;
    idxAtEnd   = (idxQ == IDX_W'(NUM_STEPS - 1));
    if (maintMode) begin
      opCompl = 3'b000;
      opPort  = cur.compl[2:1];
      opDimm  = cur.compl[0];
    end else begin
      opCompl = cur.compl;
      opPort  = 2'b00;
      opDimm  = 1'b0;
    end
  end

endmodule

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
  import mbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startPulse,
  input  logic       stopPulse,
  input  logic       opDone,
  input  logic       failIn,
  input  logic       lastStep,
  input  logic       idxAtEnd,
  output seqStrobe_t strobe,
  output logic       busyQ,
  output logic       doneQ,
  output logic       failQ
);

  logic startAcc;
  logic stopAcc;
  logic stepAck;
  logic finish;

  always_comb begin
    startAcc      = startPulse && !busyQ;
    stopAcc       = stopPulse && busyQ;
    stepAck       = busyQ && opDone && !stopPulse;
    finish        = stepAck && (lastStep || idxAtEnd);
    strobe.clrIdx = startAcc;
    strobe.incIdx = stepAck && !finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
    end else if (stopAcc) begin
      busyQ <= 1'b0;
    end else if (startAcc) begin
      busyQ <= 1'b1;
      doneQ <= 1'b0;
    end else if (finish) begin
      busyQ <= 1'b0;
      doneQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      failQ <= 1'b0;
    end else if (failIn) begin
      failQ <= 1'b1;
    end else if (startAcc) begin
      failQ <= 1'b0;
    end
  end

endmodule

// File: rtl/mbs_seq.sv
module mbs_seq
  import mbs_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int SLOTS    = 4,
  parameter int REG_W    = 64,
  localparam int NUM_STEPS = NUM_REGS * SLOTS,
  localparam int IDX_W     = $clog2(NUM_STEPS),
  localparam int ADDR_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgWrAddr,
  input  logic [REG_W-1:0]  cfgWrData,
  input  logic              startPulse,
  input  logic              stopPulse,
  input  logic              maintMode,
  input  logic              opDone,
  input  logic              failIn,
  output logic              opValid,
  output logic [IDX_W-1:0]  opIndex,
  output logic [3:0]        opType,
  output logic [2:0]        opCompl,
  output logic              opRevAddr,
  output logic              opRandAddr,
  output logic [2:0]        opDataMode,
  output logic              opEcc,
  output logic [1:0]        opRangeSel,
  output logic [1:0]        opPort,
  output logic              opDimm,
  output logic              statBusy,
  output logic              statDone,
  output logic              statFail
);

  seqStrobe_t strobe;
  logic       lastStep;
  logic       idxAtEnd;

  mbs_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .startPulse (startPulse),
    .stopPulse  (stopPulse),
    .opDone     (opDone),
    .failIn     (failIn),
    .lastStep   (lastStep),
    .idxAtEnd   (idxAtEnd),
    .strobe     (strobe),
    .busyQ      (statBusy),
    .doneQ      (statDone),
    .failQ      (statFail)
  );

  mbs_datapath #(
    .NUM_REGS (NUM_REGS),
    .SLOTS    (SLOTS),
    .REG_W    (REG_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfgWrEn    (cfgWrEn),
    .cfgWrAddr  (cfgWrAddr),
    .cfgWrData  (cfgWrData),
    .maintMode  (maintMode),
    .strobe     (strobe),
    .opIndex    (opIndex),
    .opType     (opType),
    .opCompl    (opCompl),
    .opRevAddr  (opRevAddr),
    .opRandAddr (opRandAddr),
    .opDataMode (opDataMode),
    .opEcc      (opEcc),
    .opRangeSel (opRangeSel),
    .opPort     (opPort),
    .opDimm     (opDimm),
    .lastStep   (lastStep),
    .idxAtEnd   (idxAtEnd)
  );

  assign opValid = statBusy;

endmodule

// File: rtl/mbs_seq_chk.sv
module mbs_seq_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             startPulse,
  input logic             stopPulse,
  input logic             maintMode,
  input logic             opDone,
  input logic             failIn,
  input logic [IDX_W-1:0] opIndex,
  input logic [1:0]       opPort,
  input logic             opDimm,
  input logic             statBusy,
  input logic             statDone,
  input logic             statFail
);

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (startPulse && !statBusy) |=> (statBusy && opIndex == '0 && !statDone));

  p_start_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (startPulse && statBusy && !opDone && !stopPulse) |=> (statBusy && $stable(opIndex)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (statBusy && !opDone && !stopPulse) |=> (statBusy && $stable(opIndex)));

  p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (statBusy && opDone && !stopPulse) |=>
      (!statBusy || opIndex == IDX_W'($past(opIndex) + 1'b1)));

  p_busy_done_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(statBusy && statDone));

  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stopPulse && statBusy) |=> (!statBusy && !statDone));

  p_fail_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    failIn |=> statFail);

  p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (statFail && !startPulse) |=> statFail);

  p_maint_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !maintMode |-> (opPort == 2'b00 && !opDimm));

endmodule

bind mbs_seq mbs_seq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .startPulse (startPulse),
  .stopPulse  (stopPulse),
  .maintMode  (maintMode),
  .opDone     (opDone),
  .failIn     (failIn),
  .opIndex    (opIndex),
  .opPort     (opPort),
  .opDimm     (opDimm),
  .statBusy   (statBusy),
  .statDone   (statDone),
  .statFail   (statFail)
);

// File: tb/mbs_seq_tb.sv
module mbs_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NSTEP = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgWrAddr = '0;
  logic [63:0] cfgWrData = '0;
  logic        startPulse = 1'b0;
  logic        stopPulse = 1'b0;
  logic        maintMode = 1'b0;
  logic        opDone = 1'b0;
  logic        failIn = 1'b0;
  logic        opValid;
  logic [4:0]  opIndex;
  logic [3:0]  opType;
  logic [2:0]  opCompl;
  logic        opRevAddr;
  logic        opRandAddr;
  logic [2:0]  opDataMode;
  logic        opEcc;
  logic [1:0]  opRangeSel;
  logic [1:0]  opPort;
  logic        opDimm;
  logic        statBusy;
  logic        statDone;
  logic        statFail;

  int checkCount = 0;
  int failCount  = 0;
  logic [15:0] mirror [NSTEP];

  always #(CLK_PERIOD / 2) clk = ~clk;

  mbs_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr),
    .cfgWrData(cfgWrData), .startPulse(startPulse), .stopPulse(stopPulse),
    .maintMode(maintMode), .opDone(opDone), .failIn(failIn),
    .opValid(opValid), .opIndex(opIndex), .opType(opType), .opCompl(opCompl),
    .opRevAddr(opRevAddr), .opRandAddr(opRandAddr), .opDataMode(opDataMode),
    .opEcc(opEcc), .opRangeSel(opRangeSel), .opPort(opPort), .opDimm(opDimm),
    .statBusy(statBusy), .statDone(statDone), .statFail(statFail)
  );

  wire [17:0] actDesc = {opType, opCompl, opRevAddr, opRandAddr, opDataMode,
                         opEcc, opRangeSel, opPort, opDimm};

  // Expected descriptor from the field positions of R2, R9, R10.
  function automatic logic [17:0] expectDesc(logic [15:0] w, logic mm);
    return {w[15:12], (mm ? 3'b000 : w[11:9]), w[8], w[7], w[6:4],
            w[2], w[1:0], (mm ? w[11:10] : 2'b00), (mm ? w[9] : 1'b0)};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic loadProg();
    for (int r = 0; r < 8; r++) begin
      @(negedge clk);
      cfgWrEn   = 1'b1;
      cfgWrAddr = 3'(r);
      cfgWrData = {mirror[4*r], mirror[4*r+1], mirror[4*r+2], mirror[4*r+3]};
    end
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic stepOne(int k, logic mm);
    int idle;
    chk("R1 index", 64'(opIndex), 64'(k));
    chk("R2/R9/R10 descriptor", 64'(actDesc), 64'(expectDesc(mirror[k], mm)));
    idle = $urandom_range(0, 2);
    repeat (idle) @(negedge clk);
    chk("R4 hold", 64'({opValid, opIndex}), 64'({1'b1, 5'(k)}));
    opDone = 1'b1;
    @(negedge clk);
    opDone = 1'b0;
  endtask

  task automatic runProg(int last, logic mm, string endReq);
    maintMode = mm;
    pulseStart();
    chk("R3 start", 64'({statBusy, opValid, statDone, opIndex}), 64'({3'b110, 5'd0}));
    for (int k = 0; k <= last; k++) stepOne(k, mm);
    chk(endReq, 64'({statBusy, opValid, statDone}), 64'(3'b001));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NSTEP; i++) mirror[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk("R11 status", 64'({statBusy, statDone, statFail, opValid}), 64'(0));

    // R11 + R6: zero storage, no last flag, runs all 32 steps
    runProg(31, 1'b0, "R6 end after step 31");

    // R1 layout with distinct words, last flag (bit 12 = word[3]) on step 11
    for (int i = 0; i < NSTEP; i++) mirror[i] = 16'((i * 16'h0913) ^ 16'hA5F4) & 16'hFFF7;
    mirror[11] = mirror[11] | 16'h0008;
    loadProg();
    runProg(11, 1'b0, "R5 end on last flag");

    // Random programs; alternate maintenance mode (R9)
    for (int it = 0; it < 6; it++) begin
      int last;
      for (int i = 0; i < NSTEP; i++) mirror[i] = 16'($urandom()) & 16'hFFF7;
      last = (it == 3) ? 31 : $urandom_range(0, 31);
      if (it != 3) mirror[last] = mirror[last] | 16'h0008;
      loadProg();
      runProg(last, 1'(it % 2), (it == 3) ? "R6 end after step 31" : "R5 end on last flag");
    end

    // Start-while-busy and fail flag behaviour
    for (int i = 0; i < NSTEP; i++) mirror[i] = 16'(16'h1000 + i * 16'h0011) & 16'hFFF7;
    mirror[5] = mirror[5] | 16'h0008;
    loadProg();
    runProgPart();

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  task automatic runProgPart();
    maintMode = 1'b0;
    pulseStart();
    stepOne(0, 1'b0);
    stepOne(1, 1'b0);
    @(negedge clk);
    failIn = 1'b1;
    @(negedge clk);
    failIn = 1'b0;
    chk("R8 fail set", 64'(statFail), 64'(1));
    pulseStart();
    chk("R3 start ignored", 64'({statBusy, statFail, opIndex}), 64'({2'b11, 5'd2}));
    for (int k = 2; k <= 5; k++) stepOne(k, 1'b0);
    chk("R8 sticky", 64'({statBusy, statDone, statFail}), 64'(3'b011));
    // start and failIn in the same cycle: fail wins
    @(negedge clk);
    startPulse = 1'b1;
    failIn     = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    failIn     = 1'b0;
    chk("R8 set beats start", 64'({statBusy, statDone, statFail}), 64'(3'b101));
    // stop mid-run
    @(negedge clk);
    stopPulse = 1'b1;
    @(negedge clk);
    stopPulse = 1'b0;
    chk("R7 stop", 64'({statBusy, opValid, statDone}), 64'(3'b000));
    // fresh start clears fail
    pulseStart();
    chk("R8 cleared by start", 64'({statBusy, statFail, opIndex}), 64'({2'b10, 5'd0}));
    for (int k = 0; k < 5; k++) stepOne(k, 1'b0);
    // stop together with completion of the final step
    chk("R1 index", 64'(opIndex), 64'(5));
    opDone    = 1'b1;
    stopPulse = 1'b1;
    @(negedge clk);
    opDone    = 1'b0;
    stopPulse = 1'b0;
    chk("R7 stop beats final completion", 64'({statBusy, statDone}), 64'(2'b00));
  endtask

endmodule